// File: doc/BRIEF.md
# Digit-Wide Shift Register with Parallel Load

A chain of digit stages, each a register of `DIGIT_W` bits, all captured on the falling edge of the clock. One select input chooses, for every stage at once, between two sources: the parallel load bus, or the stage just upstream. In shift mode each clock moves every digit one whole stage along the chain. The first stage takes a digit from a dedicated serial input, and the digit in the last stage is discarded. In load mode one clock writes a complete new word into every stage.

With the default 4-bit digit the chain holds decimal digits. It then moves one decimal place per clock and can still be reloaded in a single cycle. A different digit width gives a binary register that moves a chosen number of bit positions per clock. A synchronous clear overrides both modes. An asynchronous active-low reset empties the chain, and its release is synchronized to the falling clock edge.

Top module: `digit_shift_reg`

## Requirements
- R1: While `rst_n` is low, `q_bus` reads all zeros, without waiting for a clock edge.
- R2: With `clr` low and `shift_sel` low (load), a falling clock edge makes `q_bus` equal to the value `load_bus` had at that edge. Stage k occupies bits [k*DIGIT_W +: DIGIT_W] in both buses.
- R3: With `clr` low and `shift_sel` high (shift), a falling clock edge puts `ser_digit` into stage 0 and the previous content of stage k-1 into stage k. The previous content of the last stage is lost.
- R4: N_DIGITS consecutive shift clocks replace the whole chain with the serial digits, and the first digit shifted in ends up in the last stage.
- R5: With `clr` high, a falling clock edge zeroes every stage, whatever the value of `shift_sel`.
- R6: Between falling edges, `q_bus` holds its value. Changes on `load_bus`, `ser_digit`, `shift_sel` or `clr`, and rising clock edges, leave it unchanged.
- R7: After `rst_n` rises, the first two falling edges leave `q_bus` at zero. The third falling edge performs the selected operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the chain captures on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear, with priority over shift and load |
| shift_sel | input | 1 | 1 = shift the chain by one digit, 0 = parallel load |
| ser_digit | input | DIGIT_W | Digit entering stage 0 in shift mode |
| load_bus | input | N_DIGITS*DIGIT_W | Parallel word for all stages |
| q_bus | output | N_DIGITS*DIGIT_W | Contents of all stages |

## Verification
The table runs a load, then three shifts with distinct serial digits, so that a digit sent to the wrong stage or shifted the wrong way shows up as a mismatch. Clears are tried with each select value to confirm that clear wins over both modes. Loads of distinct non-decimal words catch a crossed or dropped bit inside a stage's selector. An all-ones digit walked through a zero chain separates stage order from bit order. Directed steps change every input in the middle of a cycle, check that nothing moves until the falling edge, and count the edges ignored after reset release.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_SHIFT = 1'b1
  } dsr_op_e;
endpackage

// File: rtl/dsr_rst_sync.sv
module dsr_rst_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[SYNC_STAGES-1];

  // R1
  rst_follow_chk: assert property (@(negedge clk) !rst_n |-> !rst_sync_n)
    else $error("internal reset not asserted with rst_n");
endmodule

// File: rtl/dsr_digit_mux.sv
module dsr_digit_mux
  import dsr_pkg::*;
#(
  parameter int unsigned DIGIT_W = 4
) (
  input  dsr_op_e              op,
  input  logic [DIGIT_W-1:0]   par_digit,
  input  logic [DIGIT_W-1:0]   up_digit,
  output logic [DIGIT_W-1:0]   sel_digit
);
  for (genvar b = 0; b < DIGIT_W; b++) begin : g_bit
    assign sel_digit[b] = (op == OP_SHIFT) ? up_digit[b] : par_digit[b];
  end
endmodule

// File: rtl/dsr_digit_stage.sv
module dsr_digit_stage
  import dsr_pkg::*;
#(
  parameter int unsigned DIGIT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  dsr_op_e            op,
  input  logic [DIGIT_W-1:0] up_digit,
  input  logic [DIGIT_W-1:0] par_digit,
  output logic [DIGIT_W-1:0] q_digit
);
  logic [DIGIT_W-1:0] sel_digit;
  logic [DIGIT_W-1:0] d_nxt;

  dsr_digit_mux #(.DIGIT_W(DIGIT_W)) u_mux (
    .op        (op),
    .par_digit (par_digit),
    .up_digit  (up_digit),
    .sel_digit (sel_digit)
  );

  always_comb begin
    if (clr) d_nxt = '0;
    else     d_nxt = sel_digit;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) q_digit <= '0;
    else        q_digit <= d_nxt;
  end

  // R5
  stage_clr_chk: assert property (@(negedge clk) disable iff (!rst_n)
    clr |=> (q_digit == '0))
    else $error("stage not cleared");

  // R3
  stage_shift_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (!clr && op == OP_SHIFT) |=> (q_digit == $past(up_digit)))
    else $error("stage did not take upstream digit");

  // R2
  stage_load_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (!clr && op == OP_LOAD) |=> (q_digit == $past(par_digit)))
    else $error("stage did not take parallel digit");
endmodule

// File: rtl/digit_shift_reg.sv
module digit_shift_reg
  import dsr_pkg::*;
#(
  parameter int unsigned DIGIT_W     = 4,
  parameter int unsigned N_DIGITS    = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        shift_sel,
  input  logic [DIGIT_W-1:0]          ser_digit,
  input  logic [N_DIGITS*DIGIT_W-1:0] load_bus,
  output logic [N_DIGITS*DIGIT_W-1:0] q_bus
);
  localparam int unsigned BUS_W = N_DIGITS * DIGIT_W;

  logic    rst_int_n;
  dsr_op_e op;
  logic [DIGIT_W-1:0] up_chain [N_DIGITS];

  assign op = shift_sel ? OP_SHIFT : OP_LOAD;

  dsr_rst_sync #(.SYNC_STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  for (genvar k = 0; k < N_DIGITS; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign up_chain[k] = ser_digit;
    end else begin : g_link
      assign up_chain[k] = q_bus[(k-1)*DIGIT_W +: DIGIT_W];
    end

    dsr_digit_stage #(.DIGIT_W(DIGIT_W)) u_stage (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .clr       (clr),
      .op        (op),
      .up_digit  (up_chain[k]),
      .par_digit (load_bus[k*DIGIT_W +: DIGIT_W]),
      .q_digit   (q_bus[k*DIGIT_W +: DIGIT_W])
    );
  end

  // R2
  bus_load_chk: assert property (@(negedge clk) disable iff (!rst_int_n)
    (!clr && !shift_sel) |=> (q_bus == $past(load_bus)))
    else $error("parallel load mismatch");

  // R3
  head_shift_chk: assert property (@(negedge clk) disable iff (!rst_int_n)
    (!clr && shift_sel) |=> (q_bus[DIGIT_W-1:0] == $past(ser_digit)))
    else $error("serial digit not in stage 0");

  // R5
  bus_clr_chk: assert property (@(negedge clk) disable iff (!rst_int_n)
    clr |=> (q_bus == {BUS_W{1'b0}}))
    else $error("chain not cleared");
endmodule

// File: tb/digit_shift_reg_bench.sv
module digit_shift_reg_bench;
  localparam int W = 4;
  localparam int N = 3;
  localparam int BW = W * N;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst_n, clr, shift_sel;
  logic [W-1:0]  ser_digit;
  logic [BW-1:0] load_bus;
  logic [BW-1:0] q_bus;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  digit_shift_reg #(.DIGIT_W(W), .N_DIGITS(N)) u_digit_shift_reg (
    .clk(clk), .rst_n(rst_n), .clr(clr), .shift_sel(shift_sel),
    .ser_digit(ser_digit), .load_bus(load_bus), .q_bus(q_bus)
  );

  // {clr, shift_sel, ser_digit[3:0], load_bus[11:0], expected q_bus[11:0]}
  localparam logic [29:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'h0, 12'h321, 12'h321},
    {1'b0, 1'b1, 4'h4, 12'h000, 12'h214},
    {1'b0, 1'b1, 4'h5, 12'hEEE, 12'h145},
    {1'b0, 1'b1, 4'h6, 12'h000, 12'h456},
    {1'b0, 1'b0, 4'h1, 12'h987, 12'h987},
    {1'b1, 1'b1, 4'h9, 12'h123, 12'h000},
    {1'b0, 1'b0, 4'h0, 12'hA5F, 12'hA5F},
    {1'b1, 1'b0, 4'h3, 12'h777, 12'h000},
    {1'b0, 1'b1, 4'hF, 12'h888, 12'h00F},
    {1'b0, 1'b1, 4'h0, 12'h888, 12'h0F0},
    {1'b0, 1'b1, 4'h0, 12'h888, 12'hF00},
    {1'b0, 1'b1, 4'h3, 12'h888, 12'h003}
  };

  task automatic check(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: q_bus=%h expected %h", tag, act, exp);
    end
  endtask

  // apply inputs, let one falling edge capture, sample mid low phase
  task automatic step(input logic c, input logic s, input logic [W-1:0] sd, input logic [BW-1:0] lb);
    clr = c; shift_sel = s; ser_digit = sd; load_bus = lb;
    @(negedge clk); #5;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; shift_sel = 1'b0; ser_digit = '0; load_bus = 12'hABC;
    @(negedge clk); #5;
    check("R1 reset holds zero", q_bus, '0);
    @(negedge clk); #5;
    check("R1 reset ignores load", q_bus, '0);

    // R7: release mid cycle with a load pending
    rst_n = 1'b1;
    @(negedge clk); #5;
    check("R7 first edge after release", q_bus, '0);
    @(negedge clk); #5;
    check("R7 second edge after release", q_bus, '0);
    @(negedge clk); #5;
    check("R7 third edge loads", q_bus, 12'hABC);

    for (int i = 0; i < NV; i++) begin
      logic [29:0] v;
      v = VEC[i];
      step(v[29], v[28], v[27:24], v[23:12]);
      check(v[29] ? "R5 clear" : (v[28] ? "R3 shift" : "R2 load"), q_bus, v[11:0]);
    end

    // R4: three shifts fully replace the chain
    step(1'b0, 1'b0, 4'h0, 12'hFFF);
    step(1'b0, 1'b1, 4'h1, 12'h000);
    step(1'b0, 1'b1, 4'h2, 12'h000);
    step(1'b0, 1'b1, 4'h3, 12'h000);
    check("R4 full replacement", q_bus, 12'h123);

    // R6: inputs toggle and a rising edge passes, no falling edge
    clr = 1'b1; shift_sel = 1'b0; load_bus = 12'h5A5; ser_digit = 4'h9;
    #2;
    check("R6 hold after input change", q_bus, 12'h123);
    @(posedge clk); #3;
    check("R6 rising edge no capture", q_bus, 12'h123);
    clr = 1'b0; shift_sel = 1'b1;
    #2;
    check("R6 hold after select change", q_bus, 12'h123);
    @(negedge clk); #5;
    check("R3 shift after hold", q_bus, 12'h239);

    // R1: asynchronous reset between edges
    @(posedge clk); #3;
    rst_n = 1'b0;
    #1;
    check("R1 async reset mid cycle", q_bus, '0);
    @(negedge clk); #5;
    rst_n = 1'b1;
    step(1'b0, 1'b0, 4'h0, 12'h468);
    check("R7 gap edge one", q_bus, '0);
    step(1'b0, 1'b0, 4'h0, 12'h468);
    check("R7 gap edge two", q_bus, '0);
    step(1'b0, 1'b0, 4'h0, 12'h468);
    check("R2 load after reset", q_bus, 12'h468);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule